// File: doc/BRIEF.md
# EEPROM Image Checksum Engine

This block checks or repairs the 16-bit additive checksum that protects the leading region of a word-organised EEPROM image. After a start pulse it walks the image from word 0 upward through a generic word read port. It adds every returned word modulo 2^16 into a running sum. The serial protocol of the memory itself lies outside the block.

In validate mode the walk covers word 0 through the checksum word, and the result is a pass or fail verdict against the fixed target 0xBABA. In update mode the walk stops just before the checksum word. The block then writes the correcting value, 0xBABA minus the sum, into the checksum word with a single write request.

The read request and the write request are valid/ready channels. A raised request keeps its valid, address and data unchanged until the cycle in which ready is sampled high, and that cycle completes the transfer. The read response has no back-pressure: the block is always able to take the one response it waits for, and it ignores responses at any other time. Start, mode, done, pass and error are plain level or pulse signals.

Top module: `eeprom_sum_engine`

## Requirements
- R1: In validate mode (mode_update=0) the block reads words 0..SUM_IDX, and pass=1 at done exactly when their sum modulo 2^16 equals 0xBABA; otherwise pass=0 and err=0.
- R2: In update mode (mode_update=1) the block reads words 0..SUM_IDX-1 and issues exactly one write, to address SUM_IDX, with data 0xBABA minus their 16-bit sum. It signals done with pass=1 once that write is accepted.
- R3: A read response with rd_rsp_err=1 ends the operation. Done follows with err=1 and pass=0, and no further read and no write is issued.
- R4: At most one read is outstanding. Addresses are issued in ascending order from 0, and a new request is issued only after the response to the previous one.
- R5: A read request (valid, address) and a write request (valid, address, data) stay unchanged while ready is low.
- R6: Done is a one-cycle pulse. Pass and err change only with done or with an accepted start, which clears both. They never are 1 together.
- R7: A start pulse that arrives while an operation is in progress has no effect on its reads, its result or the number of done pulses.
- R8: After reset the outputs done, pass, err, rd_req_valid and wr_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| mode_update | input | 1 | 0 validate, 1 update; sampled with start |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted when high with valid |
| rd_req_addr | output | ADDR_W | Word address of the read |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | WORD_W | Read response word |
| rd_rsp_err | input | 1 | Read response carries an error |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted when high with valid |
| wr_addr | output | ADDR_W | Write address, always SUM_IDX |
| wr_data | output | WORD_W | Correcting checksum word |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Checksum correct (validate) or written (update) |
| err | output | 1 | Operation aborted by a read error |

## Verification
The assertions assume that the memory side answers each accepted read with exactly one response strobe and sends no strobe when nothing is outstanding. They also assume that reset is applied before the first start and that SUM_IDX is at least 1. The bench memory model keeps to this. It latches an accepted read and returns a single response after a chosen latency. Ready on both request channels comes from a fixed pattern, either always high or stalled on most cycles, so that the hold rules are exercised without ever breaking the one-response contract.

// File: rtl/ckeng_pkg.sv
package ckeng_pkg;
  localparam logic [15:0] CK_TARGET = 16'hBABA;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_WR   = 2'd3
  } ck_state_e;
endpackage

// File: rtl/ckeng_acc.sv
module ckeng_acc #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] sum_nxt
);
  logic [WORD_W-1:0] sum_q;

  // running sum including the word on din, wraps modulo 2^WORD_W
  assign sum_nxt = sum_q + din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= '0;
    else if (add_en) sum_q <= sum_nxt;
  end
endmodule

// File: rtl/ckeng_seq.sv
module ckeng_seq
  import ckeng_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int SUM_IDX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_update,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic              rd_rsp_err,
  input  logic [WORD_W-1:0] sum_nxt,
  output logic              acc_clr,
  output logic              acc_en,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  output logic              done,
  output logic              pass,
  output logic              err
);
  localparam logic [ADDR_W-1:0] LAST_VAL = ADDR_W'(SUM_IDX);
  localparam logic [ADDR_W-1:0] LAST_UPD = ADDR_W'(SUM_IDX - 1);
  localparam logic [WORD_W-1:0] TARGET   = WORD_W'(CK_TARGET);

  ck_state_e         state;
  logic [ADDR_W-1:0] idx;
  logic              mode_q;
  logic [WORD_W-1:0] wdata_q;
  logic              done_q, pass_q, err_q;
  logic [ADDR_W-1:0] last_idx;

  assign last_idx     = mode_q ? LAST_UPD : LAST_VAL;
  assign rd_req_valid = (state == ST_REQ);
  assign rd_req_addr  = idx;
  assign wr_valid     = (state == ST_WR);
  assign wr_data      = wdata_q;
  assign done         = done_q;
  assign pass         = pass_q;
  assign err          = err_q;
  assign acc_clr      = (state == ST_IDLE) && start;
  assign acc_en       = (state == ST_WAIT) && rd_rsp_valid && !rd_rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      mode_q  <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q <= mode_update;
          idx    <= '0;
          pass_q <= 1'b0;
          err_q  <= 1'b0;
          state  <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (idx == last_idx) begin
            if (mode_q) begin
              wdata_q <= TARGET - sum_nxt;
              state   <= ST_WR;
            end else begin
              pass_q <= (sum_nxt == TARGET);
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_REQ;
          end
        end
        ST_WR: if (wr_ready) begin
          pass_q <= 1'b1;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid);
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_valid && !rd_req_valid);
endmodule

// File: rtl/eeprom_sum_engine.sv
module eeprom_sum_engine #(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int SUM_IDX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_update,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              done,
  output logic              pass,
  output logic              err
);
  logic              acc_clr, acc_en;
  logic [WORD_W-1:0] sum_nxt;

  assign wr_addr = ADDR_W'(SUM_IDX);

  ckeng_acc #(.WORD_W(WORD_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .add_en  (acc_en),
    .din     (rd_rsp_data),
    .sum_nxt (sum_nxt)
  );

  ckeng_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SUM_IDX(SUM_IDX)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode_update  (mode_update),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_err   (rd_rsp_err),
    .sum_nxt      (sum_nxt),
    .acc_clr      (acc_clr),
    .acc_en       (acc_en),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .done         (done),
    .pass         (pass),
    .err          (err)
  );

  // R6
  pass_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && err));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(pass) && $stable(err)) |-> done || $past(start));
endmodule

// File: tb/tb_eeprom_sum_engine.sv
`timescale 1ns/1ps
module tb_eeprom_sum_engine;
  localparam int SUM_IDX = 63;
  localparam logic [15:0] TGT = 16'hBABA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_update = 1'b0;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [7:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
  logic [15:0] rd_rsp_data = '0;
  logic wr_valid, wr_ready = 1'b0;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;
  logic done, pass, err;

  always #2.5 clk = ~clk;

  eeprom_sum_engine #(.SUM_IDX(SUM_IDX)) dut (.*);

  logic [15:0] mem [0:SUM_IDX];
  int lat = 0, stall = 0, err_addr = -1;
  int rd_cnt, wr_cnt, order_bad, exp_addr, done_cnt;
  logic [7:0] last_wa;
  logic [15:0] last_wd;
  int checks = 0, fails = 0;
  int cyc = 0;
  logic r_pass, r_err;

  // memory model: acts at negedges only
  initial begin
    bit pend = 0; int cnt = 0; logic [7:0] paddr = '0;
    logic rdy_r, rdy_w;
    forever begin
      @(negedge clk);
      cyc++;
      rdy_r = stall ? (cyc % 3 == 0) : 1'b1;
      rdy_w = stall ? (cyc % 4 == 0) : 1'b1;
      rd_rsp_valid = 1'b0;
      rd_rsp_err   = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem[paddr[5:0]];
          rd_rsp_err   = (int'(paddr) == err_addr);
          pend = 0;
        end else cnt--;
      end
      if (rd_req_valid && rdy_r) begin
        if (pend || int'(rd_req_addr) != exp_addr) order_bad++;
        exp_addr++;
        rd_cnt++;
        pend = 1; cnt = lat; paddr = rd_req_addr;
      end
      rd_req_ready = rdy_r;
      if (wr_valid && rdy_w) begin
        wr_cnt++; last_wa = wr_addr; last_wd = wr_data;
      end
      wr_ready = rdy_w;
      if (done) done_cnt++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i <= SUM_IDX; i++) mem[i] = 16'(i * 16'h1357 + seed * 16'h0F0D + 16'h22);
  endtask

  // runs one operation; optional second start while busy
  task automatic run_op(bit upd, bit extra);
    rd_cnt = 0; wr_cnt = 0; order_bad = 0; exp_addr = 0; done_cnt = 0;
    @(negedge clk); start = 1'b1; mode_update = upd;
    @(negedge clk); start = 1'b0;
    // R6: accepted start clears the result flags
    chk("R6 clear pass", int'(pass), 0);
    chk("R6 clear err", int'(err), 0);
    for (int i = 0; i < 5000; i++) begin
      if (done) break;
      if (extra && i == 20) start = 1'b1;
      if (extra && i == 21) begin start = 1'b0; mode_update = ~upd; end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R6 done seen", int'(done), 1);
    r_pass = pass; r_err = err;
    repeat (6) @(negedge clk);
    chk("R6 done pulse count", done_cnt, 1);
    chk("R6 pass held", int'(pass), int'(r_pass));
    chk("R6 err held", int'(err), int'(r_err));
    chk("R4 order/outstanding", order_bad, 0);
  endtask

  task automatic t_reset();
    chk("R8 done", int'(done), 0);
    chk("R8 pass", int'(pass), 0);
    chk("R8 err", int'(err), 0);
    chk("R8 rd_req_valid", int'(rd_req_valid), 0);
    chk("R8 wr_valid", int'(wr_valid), 0);
  endtask

  task automatic t_validate_good();
    fill(1); mem[SUM_IDX] = TGT - sum_to(SUM_IDX);
    run_op(1'b0, 1'b0);
    chk("R1 good pass", int'(r_pass), 1);
    chk("R1 good err", int'(r_err), 0);
    chk("R1 read count", rd_cnt, SUM_IDX + 1);
    chk("R1 no write", wr_cnt, 0);
  endtask

  task automatic t_validate_bad();
    fill(2); mem[SUM_IDX] = TGT - sum_to(SUM_IDX) + 16'd1;
    run_op(1'b0, 1'b0);
    chk("R1 bad pass", int'(r_pass), 0);
    chk("R1 bad err", int'(r_err), 0);
  endtask

  task automatic t_update();
    logic [15:0] expw;
    fill(3); mem[SUM_IDX] = 16'h0000;
    expw = TGT - sum_to(SUM_IDX);
    run_op(1'b1, 1'b0);
    chk("R2 read count", rd_cnt, SUM_IDX);
    chk("R2 write count", wr_cnt, 1);
    chk("R2 write addr", int'(last_wa), SUM_IDX);
    chk("R2 write data", int'(last_wd), int'(expw));
    chk("R2 pass", int'(r_pass), 1);
    mem[SUM_IDX] = last_wd;
    // R5: revalidate with stalled ready and response latency
    stall = 1; lat = 2;
    run_op(1'b0, 1'b0);
    chk("R5 R1 stalled revalidate", int'(r_pass), 1);
    chk("R5 stalled read count", rd_cnt, SUM_IDX + 1);
    stall = 0; lat = 0;
  endtask

  task automatic t_update_stalled();
    logic [15:0] expw;
    fill(5);
    expw = TGT - sum_to(SUM_IDX);
    stall = 1; lat = 1;
    run_op(1'b1, 1'b0);
    chk("R5 R2 stalled write data", int'(last_wd), int'(expw));
    chk("R5 stalled write count", wr_cnt, 1);
    stall = 0; lat = 0;
  endtask

  task automatic t_error();
    fill(4); err_addr = 10;
    run_op(1'b1, 1'b0);
    chk("R3 err", int'(r_err), 1);
    chk("R3 pass", int'(r_pass), 0);
    chk("R3 no write", wr_cnt, 0);
    chk("R3 reads stop", rd_cnt, 11);
    err_addr = -1;
  endtask

  task automatic t_busy_start();
    fill(6); mem[SUM_IDX] = TGT - sum_to(SUM_IDX);
    lat = 1;
    run_op(1'b0, 1'b1);
    chk("R7 pass unchanged", int'(r_pass), 1);
    chk("R7 read count", rd_cnt, SUM_IDX + 1);
    chk("R7 no write", wr_cnt, 0);
    lat = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_validate_good();
    t_validate_bad();
    t_update();
    t_update_stalled();
    t_error();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule